// File: doc/BRIEF.md
# Control Packet Stream Deframer

This block sits on a 32-bit valid/ready stream that carries control packets and breaks each packet into its parts. A packet opens with a 64-bit header sent as two words. If a flag bit in the header is set, a 64-bit timestamp follows as two more words. One 32-bit operation word comes next. Every word after that, up to the word marked last, is payload.

The header, the timestamp-present flag, the timestamp, and the decoded fields of the operation word are captured in registers. They are offered on a sideband with its own valid/ready pair. Payload words pass through to an output stream that keeps the input's last marker. The sideband must be taken before the next packet's header can enter.

A packet that ends before its operation word arrives is reported with a single-cycle pulse. Such a packet produces neither a sideband strobe nor payload.

Top module: `ctrl_pkt_deframer`

## Requirements
- R1: The first accepted word of a packet loads `hdrOut[31:0]` and the second loads `hdrOut[63:32]`. Both are visible from the cycle after each word is accepted.
- R2: `hasTime` equals `hdrOut[HAS_TIME_BIT]` (default bit 63, which is bit 31 of the second header word). The packet's word sequence branches on the value of that bit when the second header word is accepted.
- R3: With the flag set, the third and fourth words load `tsOut[31:0]` and `tsOut[63:32]` in that order. With the flag clear, `tsOut` is zero from the cycle after the second header word.
- R4: The operation word is decoded as follows: `opAddr` is bits 19:0, `opByteEn` is bits 23:20, `opCode` is bits 27:24 and `opStatus` is bits 31:30. Bits 29:28 are ignored.
- R5: `sbValid` rises in the cycle after the operation word is accepted. It then stays high, with all sideband fields unchanged, until a cycle in which `sbReady` is high.
- R6: While the packet is before its payload, `inTready` equals the inverse of `sbValid`. Header, timestamp and operation words therefore wait only for an unconsumed sideband.
- R7: Each payload word appears on `payTdata`/`payTlast` with `payTvalid` in the same cycle it is offered. `inTready` follows `payTready` during payload, and the word after a payload last is treated as a new header.
- R8: An operation word carrying last gives a complete packet with zero payload. The sideband is still strobed, and no word of it appears on the payload stream.
- R9: A last accepted on a header or timestamp word produces a one-cycle `badPkt` pulse in the next cycle. It produces no sideband strobe and no payload, and the next word starts a new packet.
- R10: Synchronous active-high `rst` clears every sideband field, `sbValid` and `badPkt`, and returns framing to the first header word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inTdata | input | 32 | Input stream word |
| inTlast | input | 1 | Input last-word marker |
| inTvalid | input | 1 | Input word valid |
| inTready | output | 1 | Input word accepted when high with valid |
| payTdata | output | 32 | Payload word out |
| payTlast | output | 1 | Payload last marker |
| payTvalid | output | 1 | Payload word valid |
| payTready | input | 1 | Payload sink ready |
| sbValid | output | 1 | Sideband fields valid |
| sbReady | input | 1 | Sideband consumer ready |
| hdrOut | output | 64 | Captured header |
| hasTime | output | 1 | Timestamp-present flag of the captured header |
| tsOut | output | 64 | Captured timestamp, zero when absent |
| opStatus | output | 2 | Operation status field |
| opCode | output | 4 | Operation code field |
| opByteEn | output | 4 | Operation byte enables |
| opAddr | output | 20 | Operation register address |
| badPkt | output | 1 | One-cycle pulse for a packet cut short before its operation word |

## Verification
The bench targets the four malformed cut points. A design that counts words wrongly there would either strobe a sideband for a broken packet or drift out of step and read the next header as payload.

Packets with and without the timestamp flag are interleaved. A machine that samples the flag from the wrong word, or leaves a stale timestamp visible, shows wrong `tsOut` or takes the operation word from the wrong position.

Zero-payload packets check that the word after an operation word marked last is taken as a header and not forwarded. Long stalls of `sbReady` and `payTready` check that header words are held back only by the sideband, and payload words only by the payload sink.

// File: rtl/ctrl_deframer_pkg.sv
package ctrl_deframer_pkg;

  // Framing position within a packet
  typedef enum logic [2:0] {
    FR_HDR_LO,
    FR_HDR_HI,
    FR_TS_LO,
    FR_TS_HI,
    FR_OPWORD,
    FR_PAYLOAD
  } frameState_t;

  // Load strobes from control to datapath
  typedef struct packed {
    logic [1:0] ldHdr;  // index 0 = low half, 1 = high half
    logic [1:0] ldTs;
    logic       clrTs;
    logic       ldOp;
  } fieldStrobes_t;

  // Operation word field layout
  localparam int OP_ADDR_LSB   = 0;
  localparam int OP_ADDR_W     = 20;
  localparam int OP_BE_LSB     = 20;
  localparam int OP_BE_W       = 4;
  localparam int OP_CODE_LSB   = 24;
  localparam int OP_CODE_W     = 4;
  localparam int OP_STATUS_LSB = 30;
  localparam int OP_STATUS_W   = 2;

endpackage

// File: rtl/ctrl_deframer_fsm.sv
module ctrl_deframer_fsm
  import ctrl_deframer_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inTvalid,
  input  logic          inTlast,
  input  logic          htBit,
  input  logic          payTready,
  input  logic          sbReady,
  output logic          inTready,
  output logic          payTvalid,
  output logic          sbValid,
  output logic          badPkt,
  output fieldStrobes_t strb
);

  frameState_t state, stateNext;
  logic preamble;
  logic accept;
  logic earlyEnd;

  assign preamble  = (state != FR_PAYLOAD);
  assign inTready  = preamble ? !sbValid : payTready;
  assign payTvalid = !preamble && inTvalid;
  assign accept    = inTvalid && inTready;
  assign earlyEnd  = accept && inTlast &&
                     (state == FR_HDR_LO || state == FR_HDR_HI ||
                      state == FR_TS_LO  || state == FR_TS_HI);

  always_comb begin
    stateNext = state;
    if (accept) begin
      if (inTlast) begin
        stateNext = FR_HDR_LO;
      end else begin
        case (state)
          FR_HDR_LO:  stateNext = FR_HDR_HI;
          FR_HDR_HI:  stateNext = htBit ? FR_TS_LO : FR_OPWORD;
          FR_TS_LO:   stateNext = FR_TS_HI;
          FR_TS_HI:   stateNext = FR_OPWORD;
          FR_OPWORD:  stateNext = FR_PAYLOAD;
          FR_PAYLOAD: stateNext = FR_PAYLOAD;
          default:    stateNext = FR_HDR_LO;
        endcase
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.ldHdr[0] = accept && (state == FR_HDR_LO);
    strb.ldHdr[1] = accept && (state == FR_HDR_HI);
    strb.clrTs    = strb.ldHdr[1] && !htBit;
    strb.ldTs[0]  = accept && (state == FR_TS_LO);
    strb.ldTs[1]  = accept && (state == FR_TS_HI);
    strb.ldOp     = accept && (state == FR_OPWORD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FR_HDR_LO;
      sbValid <= 1'b0;
      badPkt  <= 1'b0;
    end else begin
      state   <= stateNext;
      sbValid <= strb.ldOp || (sbValid && !sbReady);
      badPkt  <= earlyEnd;
    end
  end

endmodule

// File: rtl/ctrl_deframer_dpath.sv
module ctrl_deframer_dpath
  import ctrl_deframer_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int HAS_TIME_BIT = 63
) (
  input  logic                   clk,
  input  logic                   rst,
  input  fieldStrobes_t          strb,
  input  logic [WORD_W-1:0]      inTdata,
  input  logic                   inTlast,
  output logic [WORD_W-1:0]      payTdata,
  output logic                   payTlast,
  output logic [2*WORD_W-1:0]    hdrOut,
  output logic                   hasTime,
  output logic [2*WORD_W-1:0]    tsOut,
  output logic [OP_STATUS_W-1:0] opStatus,
  output logic [OP_CODE_W-1:0]   opCode,
  output logic [OP_BE_W-1:0]     opByteEn,
  output logic [OP_ADDR_W-1:0]   opAddr
);

  localparam int HT_WORD = HAS_TIME_BIT / WORD_W;
  localparam int HT_POS  = HAS_TIME_BIT % WORD_W;

  logic [WORD_W-1:0] hdrQ [2];
  logic [WORD_W-1:0] tsQ  [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)               hdrQ[h] <= '0;
      else if (strb.ldHdr[h]) hdrQ[h] <= inTdata;
    end
    always_ff @(posedge clk) begin
      if (rst || strb.clrTs) tsQ[h] <= '0;
      else if (strb.ldTs[h]) tsQ[h] <= inTdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opStatus <= '0;
      opCode   <= '0;
      opByteEn <= '0;
      opAddr   <= '0;
    end else if (strb.ldOp) begin
      opStatus <= inTdata[OP_STATUS_LSB +: OP_STATUS_W];
      opCode   <= inTdata[OP_CODE_LSB +: OP_CODE_W];
      opByteEn <= inTdata[OP_BE_LSB +: OP_BE_W];
      opAddr   <= inTdata[OP_ADDR_LSB +: OP_ADDR_W];
    end
  end

  assign hdrOut   = {hdrQ[1], hdrQ[0]};
  assign tsOut    = {tsQ[1], tsQ[0]};
  assign hasTime  = hdrQ[HT_WORD][HT_POS];
  assign payTdata = inTdata;
  assign payTlast = inTlast;

endmodule

// File: rtl/ctrl_pkt_deframer.sv
module ctrl_pkt_deframer
  import ctrl_deframer_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int HAS_TIME_BIT = 63
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WORD_W-1:0]      inTdata,
  input  logic                   inTlast,
  input  logic                   inTvalid,
  output logic                   inTready,
  output logic [WORD_W-1:0]      payTdata,
  output logic                   payTlast,
  output logic                   payTvalid,
  input  logic                   payTready,
  output logic                   sbValid,
  input  logic                   sbReady,
  output logic [2*WORD_W-1:0]    hdrOut,
  output logic                   hasTime,
  output logic [2*WORD_W-1:0]    tsOut,
  output logic [OP_STATUS_W-1:0] opStatus,
  output logic [OP_CODE_W-1:0]   opCode,
  output logic [OP_BE_W-1:0]     opByteEn,
  output logic [OP_ADDR_W-1:0]   opAddr,
  output logic                   badPkt
);

  localparam int HT_POS = HAS_TIME_BIT - WORD_W;

  fieldStrobes_t strb;

  ctrl_deframer_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .inTvalid  (inTvalid),
    .inTlast   (inTlast),
    .htBit     (inTdata[HT_POS]),
    .payTready (payTready),
    .sbReady   (sbReady),
    .inTready  (inTready),
    .payTvalid (payTvalid),
    .sbValid   (sbValid),
    .badPkt    (badPkt),
    .strb      (strb)
  );

  ctrl_deframer_dpath #(
    .WORD_W       (WORD_W),
    .HAS_TIME_BIT (HAS_TIME_BIT)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .inTdata  (inTdata),
    .inTlast  (inTlast),
    .payTdata (payTdata),
    .payTlast (payTlast),
    .hdrOut   (hdrOut),
    .hasTime  (hasTime),
    .tsOut    (tsOut),
    .opStatus (opStatus),
    .opCode   (opCode),
    .opByteEn (opByteEn),
    .opAddr   (opAddr)
  );

endmodule

// File: rtl/ctrl_deframer_chk.sv
module ctrl_deframer_chk #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                inTvalid,
  input logic                inTready,
  input logic                inTlast,
  input logic                payTvalid,
  input logic                payTready,
  input logic                sbValid,
  input logic                sbReady,
  input logic                hasTime,
  input logic [2*WORD_W-1:0] hdrOut,
  input logic [2*WORD_W-1:0] tsOut,
  input logic [19:0]         opAddr,
  input logic                badPkt
);

  assert_bad_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    badPkt |=> !badPkt);

  assert_bad_no_sideband_R9: assert property (@(posedge clk) disable iff (rst)
    badPkt |-> !sbValid);

  assert_sb_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (sbValid && !sbReady) |=> (sbValid && $stable(hdrOut) && $stable(tsOut) && $stable(opAddr)));

  assert_ts_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (sbValid && !hasTime) |-> (tsOut == '0));

  assert_stall_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (inTvalid && !inTready) |-> (sbValid || (payTvalid && !payTready)));

  assert_pay_last_R7: assert property (@(posedge clk) disable iff (rst)
    (payTvalid && payTready && inTlast) |=> !payTvalid);

endmodule

bind ctrl_pkt_deframer ctrl_deframer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inTvalid  (inTvalid),
  .inTready  (inTready),
  .inTlast   (inTlast),
  .payTvalid (payTvalid),
  .payTready (payTready),
  .sbValid   (sbValid),
  .sbReady   (sbReady),
  .hasTime   (hasTime),
  .hdrOut    (hdrOut),
  .tsOut     (tsOut),
  .opAddr    (opAddr),
  .badPkt    (badPkt)
);

// File: tb/ctrl_pkt_deframer_tb.sv
module ctrl_pkt_deframer_tb;

  localparam int HT_BIT = 63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] inTdata = '0;
  logic        inTlast = 1'b0;
  logic        inTvalid = 1'b0;
  logic        inTready;
  logic [31:0] payTdata;
  logic        payTlast;
  logic        payTvalid;
  logic        payTready = 1'b0;
  logic        sbValid;
  logic        sbReady = 1'b0;
  logic [63:0] hdrOut;
  logic        hasTime;
  logic [63:0] tsOut;
  logic [1:0]  opStatus;
  logic [3:0]  opCode;
  logic [3:0]  opByteEn;
  logic [19:0] opAddr;
  logic        badPkt;

  always #4 clk = ~clk;

  ctrl_pkt_deframer u_dut (
    .clk(clk), .rst(rst), .inTdata(inTdata), .inTlast(inTlast),
    .inTvalid(inTvalid), .inTready(inTready), .payTdata(payTdata),
    .payTlast(payTlast), .payTvalid(payTvalid), .payTready(payTready),
    .sbValid(sbValid), .sbReady(sbReady), .hdrOut(hdrOut), .hasTime(hasTime),
    .tsOut(tsOut), .opStatus(opStatus), .opCode(opCode), .opByteEn(opByteEn),
    .opAddr(opAddr), .badPkt(badPkt)
  );

  int compared = 0;
  int mismatched = 0;

  // stimulus words: {last, data}
  logic [32:0] wq[$];

  // reference model state
  int          idx = 0;
  bit          mHt = 0;
  logic [63:0] eHdr = '0;
  logic [63:0] eTs = '0;
  logic [31:0] eOp = '0;
  bit          eSbv = 0;
  bit          eBad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic addPkt(input bit ht, input int nPay, input int cut);
    logic [31:0] w[$];
    logic [31:0] hi;
    hi = $urandom();
    hi[HT_BIT-32] = ht;
    w.push_back($urandom());
    w.push_back(hi);
    if (ht) begin
      w.push_back($urandom());
      w.push_back($urandom());
    end
    w.push_back($urandom());
    for (int p = 0; p < nPay; p++) w.push_back($urandom());
    if (cut > 0) begin
      while (w.size() > cut) void'(w.pop_back());
    end
    for (int k = 0; k < w.size(); k++) wq.push_back({(k == w.size() - 1), w[k]});
  endtask

  task automatic checkRegs();
    chk("R1 hdrOut", hdrOut, eHdr);
    chk("R2 hasTime", {63'd0, hasTime}, {63'd0, eHdr[HT_BIT]});
    chk("R3 tsOut", tsOut, eTs);
    chk("R4 opAddr", {44'd0, opAddr}, {44'd0, eOp[19:0]});
    chk("R4 opByteEn", {60'd0, opByteEn}, {60'd0, eOp[23:20]});
    chk("R4 opCode", {60'd0, opCode}, {60'd0, eOp[27:24]});
    chk("R4 opStatus", {62'd0, opStatus}, {62'd0, eOp[31:30]});
    chk("R5 R8 sbValid", {63'd0, sbValid}, {63'd0, eSbv});
    chk("R9 badPkt", {63'd0, badPkt}, {63'd0, eBad});
  endtask

  task automatic step(input int pv, input int pr, input int ps);
    bit pre, expRdy, acc, nSbv, nBad;
    int opPos;
    logic [31:0] d;
    @(negedge clk);
    checkRegs();
    inTvalid  = (wq.size() > 0) && ($urandom_range(99) < pv);
    inTdata   = (wq.size() > 0) ? wq[0][31:0] : 32'h0;
    inTlast   = (wq.size() > 0) ? wq[0][32] : 1'b0;
    payTready = ($urandom_range(99) < pr);
    sbReady   = ($urandom_range(99) < ps);
    #1;
    pre    = (idx < 2) || (idx <= (mHt ? 4 : 2));
    expRdy = pre ? !eSbv : payTready;
    if (pre) chk("R6 inTready", {63'd0, inTready}, {63'd0, expRdy});
    else     chk("R7 inTready", {63'd0, inTready}, {63'd0, expRdy});
    chk("R7 R8 R9 payTvalid", {63'd0, payTvalid}, {63'd0, (!pre && inTvalid)});
    if (!pre && inTvalid) begin
      chk("R7 payTdata", {32'd0, payTdata}, {32'd0, inTdata});
      chk("R7 payTlast", {63'd0, payTlast}, {63'd0, inTlast});
    end
    acc  = inTvalid && expRdy;
    nSbv = eSbv && !sbReady;
    nBad = 0;
    if (acc) begin
      d = inTdata;
      if (idx == 0) eHdr[31:0] = d;
      else if (idx == 1) begin
        eHdr[63:32] = d;
        mHt = d[HT_BIT-32];
        if (!mHt) eTs = '0;
      end else if (mHt && idx == 2) eTs[31:0] = d;
      else if (mHt && idx == 3) eTs[63:32] = d;
      opPos = mHt ? 4 : 2;
      if (idx == opPos) begin
        eOp  = d;
        nSbv = 1;
      end
      if (inTlast) begin
        if (idx < opPos) nBad = 1;
        idx = 0;
      end else begin
        idx++;
      end
      void'(wq.pop_front());
    end
    eSbv = nSbv;
    eBad = nBad;
  endtask

  task automatic runQueue(input int pv, input int pr, input int ps);
    while (wq.size() > 0) step(pv, pr, ps);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: state after reset
    @(negedge clk);
    chk("R10 hdrOut reset", hdrOut, 64'd0);
    chk("R10 tsOut reset", tsOut, 64'd0);
    chk("R10 sbValid reset", {63'd0, sbValid}, 64'd0);
    chk("R10 badPkt reset", {63'd0, badPkt}, 64'd0);
    chk("R10 op reset", {34'd0, opStatus, opCode, opByteEn, opAddr}, 64'd0);

    // Directed, full throughput
    addPkt(0, 3, 0);   // R1 R4 R7
    addPkt(1, 2, 0);   // R2 R3
    addPkt(0, 0, 0);   // R8
    addPkt(1, 0, 0);   // R8 with timestamp
    addPkt(0, 1, 1);   // R9 cut on first header word
    addPkt(0, 1, 2);   // R9 cut on second header word
    addPkt(1, 1, 3);   // R9 cut on first timestamp word
    addPkt(1, 1, 4);   // R9 cut on second timestamp word
    addPkt(0, 1, 0);
    runQueue(100, 100, 100);

    // Sideband held back, payload stalled
    addPkt(1, 4, 0);
    addPkt(0, 2, 0);
    runQueue(100, 30, 10);

    // Random mix
    for (int n = 0; n < 60; n++) begin
      bit ht;
      int cut;
      ht  = $urandom_range(1);
      cut = ($urandom_range(5) == 0) ? $urandom_range(ht ? 4 : 2, 1) : 0;
      addPkt(ht, $urandom_range(5), cut);
    end
    runQueue(70, 60, 50);

    repeat (6) step(0, 100, 100);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule